// File: doc/BRIEF.md
# Indexed-access prioritized interrupt controller

This block gathers up to `NUM_IRQ` system interrupt lines into a single host interrupt. Each line is synchronized and then conditioned by a polarity bit and a type bit: it is either level sensitive (high or low) or edge sensitive (rising or falling). The result is latched into a pending status bit, and the status bit is gated by a per-line enable. Every line has a byte-wide channel number. Among the enabled pending lines, the one with the lowest channel wins, and within a channel the lowest line number wins. A registered index register reports that winner, with a flag that is set when nothing is pending.

Software reaches the block over a plain 32-bit register bus. A write is a one-cycle `bus_wr` strobe. A read is a one-cycle `bus_rd` strobe, and the data appears on `bus_rdata` after the next clock edge. Status and enables can be handled as 32-bit vectors. They can also be handled one line at a time by writing the line number to an index register, which lets a handler acknowledge or mask one source without a read-modify-write. The host output `host_irq` needs both a global enable and a host enable.

Top module: `idx_irq_ctrl`

## Requirements
- R1: After reset, the following are all zero: enables, status, channel map, type bits, the global enable (0x000, bit 0) and the host enable (0x004, bit 0). Polarity bits (0x200 + 4w) are all one, `host_irq` is low, and the winner register at 0x01C reads 0x8000_0000.
- R2: Writing a line number N below `NUM_IRQ` to 0x014 sets enable bit N, and writing it to 0x018 clears that bit. A number at or above `NUM_IRQ` changes nothing. Enable word w reads back at 0x100 + 4w (and at 0x180 + 4w).
- R3: Writing a line number N below `NUM_IRQ` to 0x010 clears status bit N alone. Every other status bit keeps its value, and an out-of-range number clears nothing. Status word w reads back at 0x080 + 4w.
- R4: Line i uses polarity bit i%32 of word 0x200 + 4w and type bit i%32 of word 0x280 + 4w, where w = i/32. Type 1 with polarity 1 pends on a rising edge. Type 1 with polarity 0 pends on a falling edge and ignores the rising edge.
- R5: An edge-type status bit stays set after its input returns to idle, until software clears it. A status bit never clears unless a write occurs.
- R6: A level-type line pends while its input is at the active level: polarity 1 means high and polarity 0 means low. Clearing it while the level persists has no lasting effect, because it pends again. Once the input is inactive, a clear holds.
- R7: Writing to 0x080 + 4w clears every status bit that is written as 1. Writing to 0x100 + 4w sets every enable bit that is written as 1. Writing to 0x180 + 4w clears every enable bit that is written as 1.
- R8: The channel of line i is byte i%4 (bits 8*(i%4)+7 : 8*(i%4)) of the word at 0x400 + 4*(i/4). The winner is the enabled pending line with the lowest channel, and a tie goes to the lowest line number.
- R9: The winner register at 0x01C returns the winning line in bits 9:0. Bit 31 is set, and bits 9:0 are zero, when no line is both pending and enabled, even if disabled lines are pending.
- R10: `host_irq` is a registered, active-high output. It is high when all three hold: global enable bit 0, the host enable, and at least one enabled pending line. The host enable is set by writing 0 to 0x008 and cleared by writing 0 to 0x00C. Any other value written there is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_IRQ | System interrupt lines, asynchronous |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| host_irq | output | 1 | Host interrupt request, active high |

## Verification
The properties assume that at most one register access happens per cycle, so that a write to an index register is the only thing that can change the selected enable or status bit in that cycle. They also assume that a status bit falls only in a cycle that follows a write. The stimulus issues strictly sequential single-cycle accesses with idle cycles between them. It changes interrupt lines only between accesses and holds each level for several cycles, so every change passes cleanly through the two-stage synchronizer before anything is read.

// File: rtl/iic_pkg.sv
package iic_pkg;
    // Control and index registers (byte offsets)
    localparam int A_GLOBAL   = 'h000;
    localparam int A_HOST_EN  = 'h004;
    localparam int A_HOST_SET = 'h008;
    localparam int A_HOST_CLR = 'h00C;
    localparam int A_STAT_ICLR = 'h010;
    localparam int A_EN_ISET  = 'h014;
    localparam int A_EN_ICLR  = 'h018;
    localparam int A_WINNER   = 'h01C;
    // Vector regions, one word per 32 lines (room for 1024 lines each)
    localparam int B_STATUS   = 'h080;
    localparam int B_EN_SET   = 'h100;
    localparam int B_EN_CLR   = 'h180;
    localparam int B_POLARITY = 'h200;
    localparam int B_KIND     = 'h280;
    // Channel bytes, four lines per word
    localparam int B_CHANNEL  = 'h400;

    localparam int CH_W  = 8;
    localparam int IDX_W = 10;
endpackage

// File: rtl/iic_input_cond.sv
module iic_input_cond #(
    parameter int NUM_IRQ = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic [NUM_IRQ-1:0] pol,
    input  logic [NUM_IRQ-1:0] kind,
    output logic [NUM_IRQ-1:0] hit
);
    logic [NUM_IRQ-1:0] meta_d, meta_q;
    logic [NUM_IRQ-1:0] sync_d, sync_q;
    logic [NUM_IRQ-1:0] prev_d, prev_q;

    always_comb begin
        meta_d = irq_in;
        sync_d = meta_q;
        prev_d = sync_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= meta_d;
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end

    // One decoder per line: edge kinds compare against the previous sample
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
        always_comb begin
            unique case ({kind[i], pol[i]})
                2'b11:   hit[i] =  sync_q[i] & ~prev_q[i];
                2'b10:   hit[i] = ~sync_q[i] &  prev_q[i];
                2'b01:   hit[i] =  sync_q[i];
                default: hit[i] = ~sync_q[i];
            endcase
        end
    end
endmodule

// File: rtl/iic_arbiter.sv
module iic_arbiter
    import iic_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic [NUM_IRQ-1:0]      pend,
    input  logic [NUM_IRQ*CH_W-1:0] chan,
    output logic [IDX_W-1:0]        win_idx,
    output logic                    win_valid
);
    logic [CH_W-1:0] best;

    // Strict less-than keeps the earlier (lower) line on a channel tie
    always_comb begin
        win_idx   = '0;
        win_valid = 1'b0;
        best      = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (pend[i] && (!win_valid || chan[i*CH_W +: CH_W] < best)) begin
                win_valid = 1'b1;
                best      = chan[i*CH_W +: CH_W];
                win_idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/idx_irq_ctrl.sv
module idx_irq_ctrl
    import iic_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int ADDR_W  = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               host_irq
);
    localparam int WORDS     = NUM_IRQ / 32;
    localparam int MAP_WORDS = NUM_IRQ / 4;
    localparam int SEL_W     = $clog2(NUM_IRQ);

    typedef struct packed {
        logic                    glb;
        logic                    hen;
        logic [NUM_IRQ-1:0]      stat;
        logic [NUM_IRQ-1:0]      en;
        logic [NUM_IRQ-1:0]      pol;
        logic [NUM_IRQ-1:0]      kind;
        logic [NUM_IRQ*CH_W-1:0] chan;
        logic [31:0]             rdata;
        logic                    irq;
        logic                    none;
        logic [IDX_W-1:0]        win;
    } state_t;

    state_t d, q;

    logic [NUM_IRQ-1:0] hit;
    logic [IDX_W-1:0]   arb_idx;
    logic               arb_valid;
    logic               idx_ok;
    logic [SEL_W-1:0]   sel;
    logic [31:0]        rd_val;

    iic_input_cond #(.NUM_IRQ(NUM_IRQ)) u_cond (
        .clk    (clk),
        .rst_n  (rst_n),
        .irq_in (irq_in),
        .pol    (q.pol),
        .kind   (q.kind),
        .hit    (hit)
    );

    iic_arbiter #(.NUM_IRQ(NUM_IRQ)) u_arb (
        .pend      (q.stat & q.en),
        .chan      (q.chan),
        .win_idx   (arb_idx),
        .win_valid (arb_valid)
    );

    always_comb begin
        d      = q;
        idx_ok = bus_wdata < 32'(NUM_IRQ);
        sel    = bus_wdata[SEL_W-1:0];

        if (bus_wr) begin
            if (bus_addr == ADDR_W'(A_GLOBAL))
                d.glb = bus_wdata[0];
            if (bus_addr == ADDR_W'(A_HOST_SET) && bus_wdata == 32'd0)
                d.hen = 1'b1;
            if (bus_addr == ADDR_W'(A_HOST_CLR) && bus_wdata == 32'd0)
                d.hen = 1'b0;
            if (bus_addr == ADDR_W'(A_STAT_ICLR) && idx_ok)
                d.stat[sel] = 1'b0;
            if (bus_addr == ADDR_W'(A_EN_ISET) && idx_ok)
                d.en[sel] = 1'b1;
            if (bus_addr == ADDR_W'(A_EN_ICLR) && idx_ok)
                d.en[sel] = 1'b0;
            for (int w = 0; w < WORDS; w++) begin
                if (bus_addr == ADDR_W'(B_STATUS + 4*w))
                    d.stat[w*32 +: 32] = q.stat[w*32 +: 32] & ~bus_wdata;
                if (bus_addr == ADDR_W'(B_EN_SET + 4*w))
                    d.en[w*32 +: 32] = q.en[w*32 +: 32] | bus_wdata;
                if (bus_addr == ADDR_W'(B_EN_CLR + 4*w))
                    d.en[w*32 +: 32] = q.en[w*32 +: 32] & ~bus_wdata;
                if (bus_addr == ADDR_W'(B_POLARITY + 4*w))
                    d.pol[w*32 +: 32] = bus_wdata;
                if (bus_addr == ADDR_W'(B_KIND + 4*w))
                    d.kind[w*32 +: 32] = bus_wdata;
            end
            for (int m = 0; m < MAP_WORDS; m++) begin
                if (bus_addr == ADDR_W'(B_CHANNEL + 4*m))
                    d.chan[m*32 +: 32] = bus_wdata;
            end
        end

        // A new detection outranks a clear in the same cycle
        d.stat = d.stat | hit;

        rd_val = '0;
        if (bus_addr == ADDR_W'(A_GLOBAL))  rd_val[0] = q.glb;
        if (bus_addr == ADDR_W'(A_HOST_EN)) rd_val[0] = q.hen;
        if (bus_addr == ADDR_W'(A_WINNER))
            rd_val = {q.none, {(31-IDX_W){1'b0}}, q.win};
        for (int w = 0; w < WORDS; w++) begin
            if (bus_addr == ADDR_W'(B_STATUS + 4*w))   rd_val = q.stat[w*32 +: 32];
            if (bus_addr == ADDR_W'(B_EN_SET + 4*w))   rd_val = q.en[w*32 +: 32];
            if (bus_addr == ADDR_W'(B_EN_CLR + 4*w))   rd_val = q.en[w*32 +: 32];
            if (bus_addr == ADDR_W'(B_POLARITY + 4*w)) rd_val = q.pol[w*32 +: 32];
            if (bus_addr == ADDR_W'(B_KIND + 4*w))     rd_val = q.kind[w*32 +: 32];
        end
        for (int m = 0; m < MAP_WORDS; m++) begin
            if (bus_addr == ADDR_W'(B_CHANNEL + 4*m)) rd_val = q.chan[m*32 +: 32];
        end
        if (bus_rd)
            d.rdata = rd_val;

        d.irq  = q.glb & q.hen & (|(q.stat & q.en));
        d.none = ~arb_valid;
        d.win  = arb_idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.pol  <= '1;
            q.none <= 1'b1;
        end else begin
            q <= d;
        end
    end

    // Plain views of state for the bound checker
    logic               glb_q, hen_q, none_q;
    logic [NUM_IRQ-1:0] stat_q, en_q;
    assign glb_q  = q.glb;
    assign hen_q  = q.hen;
    assign none_q = q.none;
    assign stat_q = q.stat;
    assign en_q   = q.en;

    assign bus_rdata = q.rdata;
    assign host_irq  = q.irq;
endmodule

// File: rtl/iic_checker.sv
module iic_checker
    import iic_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int ADDR_W  = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [31:0]        bus_wdata,
    input logic               host_irq,
    input logic               glb_q,
    input logic               hen_q,
    input logic               none_q,
    input logic [NUM_IRQ-1:0] stat_q,
    input logic [NUM_IRQ-1:0] en_q
);
    localparam int SEL_W = $clog2(NUM_IRQ);

    logic               idx_ok;
    logic [NUM_IRQ-1:0] sel_mask;
    assign idx_ok   = bus_wdata < 32'(NUM_IRQ);
    assign sel_mask = {{(NUM_IRQ-1){1'b0}}, 1'b1} << bus_wdata[SEL_W-1:0];

    assert_idx_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(A_EN_ISET) && idx_ok)
        |=> ((en_q & $past(sel_mask)) != '0));

    assert_idx_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(A_EN_ICLR) && idx_ok)
        |=> ((en_q & $past(sel_mask)) == '0));

    assert_single_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(A_STAT_ICLR))
        |=> (($past(stat_q) & ~$past(sel_mask) & ~stat_q) == '0));

    assert_sticky_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> (($past(stat_q) & ~stat_q) == '0));

    assert_winner_real_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !none_q |-> $past(|(stat_q & en_q)));

    assert_host_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> $past(glb_q && hen_q && (|(stat_q & en_q))));
endmodule

bind idx_irq_ctrl iic_checker #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .host_irq  (host_irq),
    .glb_q     (glb_q),
    .hen_q     (hen_q),
    .none_q    (none_q),
    .stat_q    (stat_q),
    .en_q      (en_q)
);

// File: tb/sim_idx_irq_ctrl.sv
module sim_idx_irq_ctrl;
    localparam int N = 64;
    localparam logic [11:0] GLB = 12'h000, HEN = 12'h004, HSET = 12'h008, HCLR = 12'h00C;
    localparam logic [11:0] SICLR = 12'h010, EISET = 12'h014, EICLR = 12'h018, WIN = 12'h01C;
    localparam logic [11:0] STAT = 12'h080, ENS = 12'h100, ENC = 12'h180;
    localparam logic [11:0] POL = 12'h200, TYP = 12'h280, MAP = 12'h400;
    localparam logic [31:0] NONE = 32'h8000_0000;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic [N-1:0]  irq_in = '0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          host_irq;

    int checks = 0, errors = 0;

    typedef struct { logic [31:0] exp; string tag; } item_t;
    item_t sb[$];
    logic  rd_seen = 1'b0;

    always #2 clk = ~clk;

    idx_irq_ctrl #(.NUM_IRQ(N), .ADDR_W(12)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .host_irq(host_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: the read data lands one edge after the strobe
    always @(posedge clk) rd_seen <= bus_rd;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (sb.size() == 0) begin
                checks++; errors++;
                $display("FAIL scoreboard: read with no expectation");
            end else begin
                item_t it;
                it = sb.pop_front();
                chk(it.tag, bus_rdata, it.exp);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        sb.push_back('{exp: e, tag: tag});
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic drive(input int i, input logic v);
        @(negedge clk);
        irq_in[i] = v;
        idle(6);
    endtask

    task automatic pin(input string tag, input logic e);
        idle(3);
        chk(tag, {31'b0, host_irq}, {31'b0, e});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run did not end");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state
        rd(GLB, 0, "R1 global");
        rd(HEN, 0, "R1 host enable");
        rd(ENS, 0, "R1 enables");
        rd(STAT, 0, "R1 status");
        rd(POL + 4, 32'hFFFF_FFFF, "R1 polarity");
        rd(TYP, 0, "R1 type");
        rd(MAP, 0, "R1 channel map");
        rd(WIN, NONE, "R1 winner");
        pin("R1 host_irq", 1'b0);

        wr(GLB, 1);
        wr(HSET, 0);
        rd(HEN, 1, "R10 host enable set");
        wr(HCLR, 5);
        rd(HEN, 1, "R10 nonzero clear ignored");

        // R2 index enables
        wr(EISET, 3);
        rd(ENS, 32'h8, "R2 set 3");
        wr(EISET, 64);
        rd(ENS + 4, 0, "R2 out of range upper word");
        rd(ENS, 32'h8, "R2 out of range lower word");
        wr(EISET, 33);
        rd(ENS + 4, 32'h2, "R2 set 33");
        wr(EICLR, 33);
        rd(ENC + 4, 0, "R2 clear 33");

        // R4 rising on 3, falling on 5
        wr(TYP, 32'h28);
        wr(POL, 32'hFFFF_FFDF);
        drive(3, 1'b1);
        rd(STAT, 32'h8, "R4 rising edge");
        rd(WIN, 32'd3, "R9 winner 3");
        pin("R10 host_irq on", 1'b1);
        drive(3, 1'b0);
        rd(STAT, 32'h8, "R5 edge stays pending");
        drive(5, 1'b1);
        rd(STAT, 32'h8, "R4 falling ignores rise");
        drive(5, 1'b0);
        rd(STAT, 32'h28, "R4 falling edge");

        // R3 index clear
        wr(SICLR, 5);
        rd(STAT, 32'h8, "R3 clear 5 only");
        wr(SICLR, 64);
        rd(STAT, 32'h8, "R3 out of range");
        wr(SICLR, 3);
        rd(STAT, 0, "R3 clear 3");
        rd(WIN, NONE, "R9 nothing pending");
        pin("R10 host_irq off", 1'b0);

        // R7 vector forms
        drive(3, 1'b1);
        drive(3, 1'b0);
        rd(STAT, 32'h8, "R7 pend again");
        wr(STAT, 32'h8);
        rd(STAT, 0, "R7 status w1c");
        wr(ENS, 32'h28);
        rd(ENC, 32'h28, "R7 enable vector set");
        wr(ENC, 32'h20);
        rd(ENS, 32'h8, "R7 enable vector clear");

        // R6 level kinds on 40 (high) and 41 (low)
        wr(EISET, 40);
        drive(40, 1'b1);
        rd(STAT + 4, 32'h100, "R6 level high pends");
        wr(STAT + 4, 32'h100);
        rd(STAT + 4, 32'h100, "R6 re-pend after w1c");
        wr(SICLR, 40);
        rd(STAT + 4, 32'h100, "R6 re-pend after index clear");
        drive(40, 1'b0);
        wr(SICLR, 40);
        rd(STAT + 4, 0, "R6 clear holds once inactive");
        wr(POL + 4, 32'hFFFF_FDFF);
        idle(4);
        rd(STAT + 4, 32'h200, "R6 level low pends");
        wr(POL + 4, 32'hFFFF_FFFF);
        wr(SICLR, 41);
        rd(STAT + 4, 0, "R6 level low cleared");

        // R8 priority
        drive(40, 1'b1);
        drive(3, 1'b1);
        drive(3, 1'b0);
        rd(WIN, 32'd3, "R8 tie lowest line");
        wr(MAP, 32'h0500_0000);
        rd(WIN, 32'd40, "R8 lower channel wins");
        wr(MAP + 40, 32'h02);
        rd(WIN, 32'd40, "R8 channel 2 beats 5");
        wr(MAP + 40, 32'h07);
        rd(WIN, 32'd3, "R8 channel 5 beats 7");
        rd(MAP, 32'h0500_0000, "R8 map readback");

        // R9 pending but disabled
        wr(ENC, 32'hFFFF_FFFF);
        wr(ENC + 4, 32'hFFFF_FFFF);
        rd(WIN, NONE, "R9 disabled pending");
        rd(STAT, 32'h8, "R9 status kept");
        pin("R10 disabled lines", 1'b0);

        // R10 gating
        wr(EISET, 3);
        pin("R10 enabled", 1'b1);
        wr(GLB, 0);
        pin("R10 global off", 1'b0);
        wr(GLB, 1);
        wr(HCLR, 0);
        pin("R10 host off", 1'b0);
        wr(HSET, 0);
        pin("R10 both on", 1'b1);

        idle(3);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule